// File: doc/BRIEF.md
# Second-Operand Shifter and Flag Unit

This block prepares the second operand of a 32-bit ALU and turns it into a result and condition flags. A register value is put through a barrel shifter that can shift left or right logically, shift right arithmetically, rotate right, or rotate right by one place through the carry flag. The shifter also yields the bit that left the word last, which becomes the shifter carry. Instead of the register path, a 16-bit constant can be chosen as the operand. It is padded with zeros to 32 bits and is not shifted.

The operand then goes to an add/subtract stage together with a first operand. It can also be passed straight to the result as a move. A scaled-index address such as base + (index × 16) is one add with a left shift of 4.

Four flags are held in a register: negative, zero, carry and overflow. They change on a clock edge only when the set-flags control is high, and they keep their value otherwise. The registered carry flag feeds back as the shifter's carry input. The shifter and the adder are purely combinational. The flag register is the only state in the block.

Top module: `op2_alu_unit`

## Requirements
- R1: With shift type LSL, LSR, ASR or ROR and a shift amount of 0, the shifter output equals the register operand and its carry equals the current C flag. Type codes 5 to 7 behave the same way for any amount.
- R2: Shift type code 0 (LSL) by n gives operand << n. The carry is operand bit 32-n for n from 1 to 32. For n above 32, both result and carry are 0.
- R3: Shift type code 1 (LSR) by n gives operand >> n. The carry is operand bit n-1 for n from 1 to 32. For n above 32, both result and carry are 0.
- R4: Shift type code 2 (ASR) by n fills the vacated upper bits with operand bit 31. The carry is operand bit n-1. For n of 32 or more, every result bit and the carry equal operand bit 31.
- R5: Shift type code 3 (ROR) by a nonzero n rotates right by n mod 32, and the carry equals result bit 31. A nonzero multiple of 32 leaves the value unchanged, with carry = operand bit 31.
- R6: Shift type code 4 (RRX) ignores the amount. It gives {C, operand[31:1]} with carry = operand bit 0.
- R7: When use_imm is 1, the second operand is {16'b0, imm_val}, the shift controls have no effect, and the shifter carry is the current C flag.
- R8: alu_op code 0 (ADD) gives result = opa + operand (mod 2^32). For example, opa + (x LSL 4) = opa + 16·x.
- R9: alu_op code 1 (SUB) gives result = opa − operand (mod 2^32). Its carry is 1 exactly when no borrow occurs (opa ≥ operand, unsigned).
- R10: For ADD and SUB, the new V is 1 exactly when the signed two's-complement result overflows.
- R11: alu_op codes 2 and 3 (MOV) give result = operand. When flags are set, C takes the shifter carry and V keeps its old value.
- R12: At a rising clock edge with set_flags = 1, N takes result bit 31, Z takes (result == 0), and C and V are updated per R9–R11. With set_flags = 0, all four flags hold.
- R13: While rst_n is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa | input | 32 | First operand |
| opb | input | 32 | Register value for the shifter |
| imm_val | input | 16 | Constant for the immediate path |
| use_imm | input | 1 | Selects the constant as second operand |
| sh_type | input | 3 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| sh_amt | input | 6 | Shift amount, 0 to 63 |
| alu_op | input | 2 | 0 ADD, 1 SUB, 2/3 MOV |
| set_flags | input | 1 | Updates flags at the next edge |
| shift_out | output | 32 | Second operand after shift or immediate select |
| shift_cy | output | 1 | Shifter carry |
| result | output | 32 | ALU result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench sweeps every shift type at amounts 0, 1, 4, 16, 31, 32, 33 and 63, with both values of the incoming carry. A shifter that forgets the amount-32 boundary would return the operand or a wrapped shift where zero or sign fill is required. A rotate that loses its carry for multiples of 32 would return a stale C. Subtraction is checked on both sides of a borrow and at signed overflow, which exposes an inverted carry convention or a wrong overflow formula. The flag checks also confirm that MOV keeps V and that flags hold when set_flags is low, so a design that updates flags unconditionally is caught.

// File: rtl/op2_pkg.sv
package op2_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MOV  = 2'd2,
        OP_MOV2 = 2'd3
    } alu_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

endpackage

// File: rtl/op2_shifter.sv
module op2_shifter #(
    parameter int DW = 32,
    localparam int AW = $clog2(DW) + 1,
    localparam int RW = $clog2(DW)
) (
    input  logic [DW-1:0] val_in,
    input  logic [2:0]    kind,
    input  logic [AW-1:0] amt,
    input  logic          cy_in,
    output logic [DW-1:0] val_out,
    output logic          cy_out
);
    import op2_pkg::*;

    localparam int EW = 2 * DW + 1;

    logic [EW-1:0]        lsl_w;
    logic [EW-1:0]        lsr_w;
    logic signed [EW-1:0] asr_w;
    logic [RW-1:0]        rot_n;
    logic [DW-1:0]        ror_v;

    always_comb begin
        // Wide windows keep the last bit shifted out at a fixed position.
        lsl_w = {{(DW+1){1'b0}}, val_in} << amt;
        lsr_w = {val_in, {(DW+1){1'b0}}} >> amt;
        asr_w = $signed({val_in, {(DW+1){1'b0}}}) >>> amt;
        rot_n = amt[RW-1:0];
        ror_v = (val_in >> rot_n) | (val_in << (DW - int'(rot_n)));

        val_out = val_in;
        cy_out  = cy_in;
        if (kind == SH_RRX) begin
            val_out = {cy_in, val_in[DW-1:1]};
            cy_out  = val_in[0];
        end else if (amt != '0) begin
            case (kind)
                SH_LSL: begin
                    val_out = lsl_w[DW-1:0];
                    cy_out  = lsl_w[DW];
                end
                SH_LSR: begin
                    val_out = lsr_w[EW-1:DW+1];
                    cy_out  = lsr_w[DW];
                end
                SH_ASR: begin
                    val_out = asr_w[EW-1:DW+1];
                    cy_out  = asr_w[DW];
                end
                SH_ROR: begin
                    val_out = ror_v;
                    cy_out  = ror_v[DW-1];
                end
                default: begin
                    val_out = val_in;
                    cy_out  = cy_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/op2_operand_sel.sv
module op2_operand_sel #(
    parameter int DW   = 32,
    parameter int IMMW = 16
) (
    input  logic [DW-1:0]   shifted,
    input  logic            shifted_cy,
    input  logic [IMMW-1:0] imm,
    input  logic            use_imm,
    input  logic            cy_in,
    output logic [DW-1:0]   opnd,
    output logic            opnd_cy
);
    logic [DW-1:0] imm_ext;

    generate
        if (IMMW < DW) begin : g_pad
            assign imm_ext = {{(DW-IMMW){1'b0}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[DW-1:0];
        end
    endgenerate

    always_comb begin
        opnd    = use_imm ? imm_ext : shifted;
        opnd_cy = use_imm ? cy_in  : shifted_cy;
    end

endmodule

// File: rtl/op2_addsub.sv
module op2_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          subtract,
    output logic [DW-1:0] sum,
    output logic          cy,
    output logic          ov
);
    logic [DW:0]   ext;
    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff = subtract ? ~b : b;
        ext   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, subtract};
        sum   = ext[DW-1:0];
        cy    = ext[DW];
        ov    = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
    end

endmodule

// File: rtl/op2_alu_unit.sv
module op2_alu_unit #(
    parameter int DW   = 32,
    parameter int IMMW = 16,
    localparam int AW  = $clog2(DW) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [IMMW-1:0] imm_val,
    input  logic            use_imm,
    input  logic [2:0]      sh_type,
    input  logic [AW-1:0]   sh_amt,
    input  logic [1:0]      alu_op,
    input  logic            set_flags,
    output logic [DW-1:0]   shift_out,
    output logic            shift_cy,
    output logic [DW-1:0]   result,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            flag_v
);
    import op2_pkg::*;

    cond_flags_t   flags_d, flags_q;
    logic [DW-1:0] sh_val;
    logic          sh_cy;
    logic [DW-1:0] as_sum;
    logic          as_cy, as_ov;
    logic          is_arith;

    op2_shifter #(.DW(DW)) u_shift (
        .val_in (opb),
        .kind   (sh_type),
        .amt    (sh_amt),
        .cy_in  (flags_q.c),
        .val_out(sh_val),
        .cy_out (sh_cy)
    );

    op2_operand_sel #(.DW(DW), .IMMW(IMMW)) u_sel (
        .shifted   (sh_val),
        .shifted_cy(sh_cy),
        .imm       (imm_val),
        .use_imm   (use_imm),
        .cy_in     (flags_q.c),
        .opnd      (shift_out),
        .opnd_cy   (shift_cy)
    );

    op2_addsub #(.DW(DW)) u_addsub (
        .a       (opa),
        .b       (shift_out),
        .subtract(alu_op == OP_SUB),
        .sum     (as_sum),
        .cy      (as_cy),
        .ov      (as_ov)
    );

    always_comb begin
        is_arith = (alu_op == OP_ADD) || (alu_op == OP_SUB);
        result   = is_arith ? as_sum : shift_out;
        flags_d  = flags_q;
        if (set_flags) begin
            flags_d.n = result[DW-1];
            flags_d.z = (result == '0);
            flags_d.c = is_arith ? as_cy : shift_cy;
            flags_d.v = is_arith ? as_ov : flags_q.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

endmodule

// File: rtl/op2_alu_checker.sv
module op2_alu_checker #(
    parameter int DW   = 32,
    parameter int IMMW = 16,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   opb,
    input logic [IMMW-1:0] imm_val,
    input logic            use_imm,
    input logic [2:0]      sh_type,
    input logic [AW-1:0]   sh_amt,
    input logic [1:0]      alu_op,
    input logic            set_flags,
    input logic [DW-1:0]   shift_out,
    input logic            shift_cy,
    input logic [DW-1:0]   result,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_c,
    input logic            flag_v
);
    p_zero_amt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && sh_amt == '0 && sh_type != 3'd4)
            |-> (shift_out == opb && shift_cy == flag_c));

    p_rrx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && sh_type == 3'd4)
            |-> (shift_out == {flag_c, opb[DW-1:1]} && shift_cy == opb[0]));

    p_imm_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        use_imm |-> (shift_out == {{(DW-IMMW){1'b0}}, imm_val} && shift_cy == flag_c));

    p_mov_keeps_v_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && alu_op[1]) |=> (flag_v == $past(flag_v)));

    p_nz_update_r12: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flag_n == $past(result[DW-1]) && flag_z == ($past(result) == '0)));

    p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_c) && $stable(flag_v)));

endmodule

bind op2_alu_unit op2_alu_checker #(.DW(DW), .IMMW(IMMW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .opb(opb), .imm_val(imm_val), .use_imm(use_imm),
    .sh_type(sh_type), .sh_amt(sh_amt), .alu_op(alu_op), .set_flags(set_flags),
    .shift_out(shift_out), .shift_cy(shift_cy), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/op2_alu_unit_bench.sv
`timescale 1ns/1ps
module op2_alu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] opa, opb;
    logic [15:0] imm_val;
    logic        use_imm;
    logic [2:0]  sh_type;
    logic [5:0]  sh_amt;
    logic [1:0]  alu_op;
    logic        set_flags;
    logic [31:0] shift_out, result;
    logic        shift_cy, flag_n, flag_z, flag_c, flag_v;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    op2_alu_unit u_op2_alu_unit (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .imm_val(imm_val),
        .use_imm(use_imm), .sh_type(sh_type), .sh_amt(sh_amt), .alu_op(alu_op),
        .set_flags(set_flags), .shift_out(shift_out), .shift_cy(shift_cy),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: step the shift one bit at a time.
    function automatic logic [32:0] ref_shift(logic [31:0] x, logic [2:0] t,
                                              int n, logic cin);
        logic [31:0] r = x;
        logic        c = cin;
        if (t == 3'd4) return {x[0], cin, x[31:1]};
        if (n == 0 || t > 3'd4) return {cin, x};
        for (int i = 0; i < n; i++) begin
            case (t)
                3'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                3'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
        return {c, r};
    endfunction

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [15:0] im, logic ui,
                         logic [2:0] t, logic [5:0] n, logic [1:0] op, logic sf);
        @(negedge clk);
        opa = a; opb = b; imm_val = im; use_imm = ui;
        sh_type = t; sh_amt = n; alu_op = op; set_flags = sf;
        #1;
    endtask

    task automatic clock_flags();
        @(posedge clk);
        #1;
        set_flags = 1'b0;
    endtask

    task automatic set_c(logic c);
        apply(c ? 32'hFFFF_FFFF : 32'h0, 32'h0, c ? 16'h1 : 16'h0, 1'b1, 3'd0, 6'd0, 2'd0, 1'b1);
        clock_flags();
    endtask

    task automatic check_flags(string req, logic [3:0] exp);
        check(req, "NZCV", {28'h0, flag_n, flag_z, flag_c, flag_v}, {28'h0, exp});
    endtask

    task automatic t_reset();
        check_flags("R13", 4'b0000);
    endtask

    task automatic t_shift_sweep();
        int amts[8] = '{0, 1, 4, 16, 31, 32, 33, 63};
        logic [31:0] pats[2] = '{32'hA5C3_0F96, 32'h8000_0001};
        string tags[4] = '{"R2", "R3", "R4", "R5"};
        for (int ci = 0; ci < 2; ci++) begin
            set_c(ci[0]);
            for (int t = 0; t < 4; t++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [32:0] e;
                        string tg;
                        e = ref_shift(pats[p], 3'(t), amts[a], ci[0]);
                        tg = (amts[a] == 0) ? "R1" : tags[t];
                        apply(32'h0, pats[p], 16'h0, 1'b0, 3'(t), 6'(amts[a]), 2'd2, 1'b0);
                        check(tg, "shift_out", shift_out, e[31:0]);
                        check(tg, "shift_cy", {31'h0, shift_cy}, {31'h0, e[32]});
                    end
                end
            end
        end
        // Undefined type codes pass through (R1).
        apply(32'h0, 32'h1234_5678, 16'h0, 1'b0, 3'd6, 6'd9, 2'd2, 1'b0);
        check("R1", "shift_out code6", shift_out, 32'h1234_5678);
        check("R1", "shift_cy code6", {31'h0, shift_cy}, {31'h0, flag_c});
    endtask

    task automatic t_rrx();
        for (int ci = 0; ci < 2; ci++) begin
            set_c(ci[0]);
            apply(32'h0, 32'h0000_0003, 16'h0, 1'b0, 3'd4, 6'd7, 2'd2, 1'b0);
            check("R6", "shift_out", shift_out, {ci[0], 31'h1});
            check("R6", "shift_cy", {31'h0, shift_cy}, 32'h1);
        end
    endtask

    task automatic t_imm();
        set_c(1'b1);
        apply(32'h0, 32'hFFFF_FFFF, 16'hBEEF, 1'b1, 3'd0, 6'd5, 2'd2, 1'b0);
        check("R7", "shift_out", shift_out, 32'h0000_BEEF);
        check("R7", "shift_cy", {31'h0, shift_cy}, 32'h1);
    endtask

    task automatic t_add_scaled();
        apply(32'h0000_1000, 32'h0000_0025, 16'h0, 1'b0, 3'd0, 6'd4, 2'd0, 1'b1);
        check("R8", "result", result, 32'h0000_1250);
        clock_flags();
        check_flags("R12", 4'b0000);
    endtask

    task automatic t_sub();
        apply(32'd5, 32'd3, 16'h0, 1'b0, 3'd0, 6'd0, 2'd1, 1'b1);
        check("R9", "result 5-3", result, 32'd2);
        clock_flags();
        check_flags("R9", 4'b0010);
        apply(32'd3, 32'd5, 16'h0, 1'b0, 3'd0, 6'd0, 2'd1, 1'b1);
        check("R9", "result 3-5", result, 32'hFFFF_FFFE);
        clock_flags();
        check_flags("R9", 4'b1000);
        apply(32'd7, 32'd7, 16'h0, 1'b0, 3'd0, 6'd0, 2'd1, 1'b1);
        clock_flags();
        check_flags("R12", 4'b0110);
    endtask

    task automatic t_overflow();
        apply(32'h7FFF_FFFF, 32'h0, 16'h1, 1'b1, 3'd0, 6'd0, 2'd0, 1'b1);
        check("R10", "result", result, 32'h8000_0000);
        clock_flags();
        check_flags("R10", 4'b1001);
        apply(32'h8000_0000, 32'h1, 16'h0, 1'b0, 3'd0, 6'd0, 2'd1, 1'b1);
        check("R10", "result", result, 32'h7FFF_FFFF);
        clock_flags();
        check_flags("R10", 4'b0011);
    endtask

    task automatic t_mov();
        // V is 1 from the previous step.
        apply(32'hDEAD_BEEF, 32'h3, 16'h0, 1'b0, 3'd1, 6'd1, 2'd2, 1'b1);
        check("R11", "result", result, 32'h1);
        clock_flags();
        check_flags("R11", 4'b0011);
        apply(32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 6'd0, 2'd3, 1'b1);
        clock_flags();
        check_flags("R11", 4'b0111);
    endtask

    task automatic t_hold();
        apply(32'h8000_0000, 32'h0, 16'h5, 1'b1, 3'd0, 6'd0, 2'd0, 1'b0);
        clock_flags();
        check_flags("R12", 4'b0111);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        opa = '0; opb = '0; imm_val = '0; use_imm = 1'b0;
        sh_type = '0; sh_amt = '0; alu_op = '0; set_flags = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_shift_sweep();
        t_rrx();
        t_imm();
        t_add_scaled();
        t_sub();
        t_overflow();
        t_mov();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule